// File: doc/BRIEF.md
# Host Command Ring Mailbox

This block keeps a small ring of 32-bit command words inside a register window. The host stores commands into fixed slot addresses. It then publishes them by writing a new value to a producer index register. On the card side, the block presents the command at the consumer index as a valid/ready stream. Each word is split into an 8-bit opcode, a 12-bit flags field and a 12-bit index. Every accepted command moves the consumer index forward by one.

The host reaches the block through a single-cycle register port. It can read back the ring slots and both index registers. A producer update that would run past unconsumed entries is refused and reported on a one-cycle error pulse. The block does not interpret the commands themselves.

Top module: `cmdring_mailbox`

## Requirements
- R1: After reset both indices read 0, every slot reads 0, `cmd_valid` is low and `ovf_err` is low.
- R2: A host write to an aligned address `RING_BASE + 4*k` (default base 0x700, k from 0 to 63) stores the word in slot k. A read of that address returns the word.
- R3: A host write to the producer register (default 0x50C) loads `host_wdata[5:0]` as the new producer index, unless R6 refuses it. Reading that address returns the index zero-extended.
- R4: `cmd_valid` is high exactly when the consumer index differs from the producer index. The output fields come from the slot at the consumer index: opcode from bits [31:24], flags from bits [23:12], index from bits [11:0].
- R5: When `cmd_valid` and `cmd_ready` are both high at a clock edge, the consumer index becomes (consumer+1) mod 64. The host reads it at the consumer register (default 0x62C). `cmd_ready` has no effect while `cmd_valid` is low.
- R6: A producer write is refused when its forward step (new−producer mod 64) exceeds the free slot count (consumer−producer−1 mod 64). A refused write leaves the producer unchanged. `ovf_err` is then high for exactly the one cycle after the write.
- R7: Both indices wrap from 63 to 0. A ring holding 63 commands drains completely through the wrap.
- R8: Host writes to the consumer register and to unmapped or misaligned addresses change no state. Reads of unmapped or misaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 12 | Host byte address (write target or read select) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| cmd_valid | output | 1 | A command is pending |
| cmd_ready | input | 1 | Consumer takes the pending command |
| cmd_opcode | output | 8 | Opcode field of the pending command |
| cmd_flags | output | 12 | Flags field of the pending command |
| cmd_index | output | 12 | Index field of the pending command |
| ovf_err | output | 1 | One-cycle pulse after a refused producer write |

## Verification
A wrong consumer index shows at once in the decoded fields, because they are drawn from the wrong slot. It also shows in the consumer register readback on the very next read. A wrong producer index, or a wrong overflow decision, changes `cmd_valid` in the cycle after the write. From then on it causes a premature empty ring or extra stale commands. A slot stored at the wrong address shows up as soon as that slot is read back or reaches the consumer.

// File: rtl/cmdring_pkg.sv
`timescale 1ns/1ps
package cmdring_pkg;
  typedef struct packed {
    logic [7:0]  opcode;
    logic [11:0] flags;
    logic [11:0] index;
  } cmd_word_t;

  // forward distance from 'from_i' to 'to_i' on a ring of power-of-two size
  function automatic int unsigned ring_gap(input int unsigned to_i,
                                           input int unsigned from_i,
                                           input int unsigned depth);
    return (to_i - from_i) & (depth - 1);
  endfunction

  // a producer move is legal when its step fits in the free slots
  function automatic logic prod_move_ok(input int unsigned new_p,
                                        input int unsigned cur_p,
                                        input int unsigned cur_c,
                                        input int unsigned depth);
    return ring_gap(new_p, cur_p, depth) <= ring_gap(cur_c, cur_p + 1, depth);
  endfunction
endpackage

// File: rtl/cmdring_regdec.sv
`timescale 1ns/1ps
module cmdring_regdec #(
  parameter int AW        = 12,
  parameter int DEPTH     = 64,
  parameter int RING_BASE = 'h700,
  parameter int PROD_OFS  = 'h50C,
  parameter int CONS_OFS  = 'h62C,
  localparam int PW       = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr,
  output logic          hit_ring,
  output logic          hit_prod,
  output logic          hit_cons,
  output logic [PW-1:0] slot
);
  logic [AW-1:0] rel;
  logic          aligned;

  always_comb begin
    rel      = addr - AW'(RING_BASE);
    aligned  = (addr[1:0] == 2'b00);
    hit_ring = aligned && (addr >= AW'(RING_BASE)) && (rel < AW'(4 * DEPTH));
    hit_prod = (addr == AW'(PROD_OFS));
    hit_cons = (addr == AW'(CONS_OFS));
    slot     = rel[PW+1:2];
  end
endmodule

// File: rtl/cmdring_store.sv
`timescale 1ns/1ps
module cmdring_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] wslot,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] cslot,
  output logic [DW-1:0] cword,
  input  logic [PW-1:0] hslot,
  output logic [DW-1:0] hword
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wslot] <= wdata;
    end
  end

  assign cword = mem[cslot];
  assign hword = mem[hslot];

  // R2: the addressed slot holds the written word after the edge
  a_r2_slot_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(wslot)] == $past(wdata));
endmodule

// File: rtl/cmdring_ptrs.sv
`timescale 1ns/1ps
module cmdring_ptrs
  import cmdring_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prod_we,
  input  logic [PW-1:0] prod_wval,
  input  logic          take,
  output logic [PW-1:0] prod_q,
  output logic [PW-1:0] cons_q,
  output logic          ovf_evt,
  output logic          ovf_q
);
  logic move_ok;

  assign move_ok = prod_move_ok(32'(prod_wval), 32'(prod_q), 32'(cons_q), DEPTH);
  assign ovf_evt = prod_we && !move_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q <= '0;
      cons_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (prod_we && move_ok) prod_q <= prod_wval;
      if (take) cons_q <= cons_q + 1'b1;
      ovf_q <= ovf_evt;
    end
  end

  a_r6_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> prod_q == $past(prod_q));
  a_r6_ovf_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_q);
  a_r3_prod_load: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_we && !ovf_evt) |=> prod_q == $past(prod_wval));
  a_r5_cons_step: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cons_q == PW'($past(cons_q) + 1'b1));
endmodule

// File: rtl/cmdring_mailbox.sv
`timescale 1ns/1ps
module cmdring_mailbox
  import cmdring_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DEPTH     = 64,
  parameter int RING_BASE = 'h700,
  parameter int PROD_OFS  = 'h50C,
  parameter int CONS_OFS  = 'h62C,
  localparam int PW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [7:0]    cmd_opcode,
  output logic [11:0]   cmd_flags,
  output logic [11:0]   cmd_index,
  output logic          ovf_err
);
  logic          hit_ring, hit_prod, hit_cons;
  logic [PW-1:0] slot, prod_q, cons_q;
  logic [31:0]   cword, hword;
  logic          take, ovf_evt;
  cmd_word_t     head;

  cmdring_regdec #(.AW(AW), .DEPTH(DEPTH), .RING_BASE(RING_BASE),
                   .PROD_OFS(PROD_OFS), .CONS_OFS(CONS_OFS)) u_dec (
    .addr(host_addr), .hit_ring(hit_ring), .hit_prod(hit_prod),
    .hit_cons(hit_cons), .slot(slot));

  cmdring_store #(.DEPTH(DEPTH), .DW(32)) u_store (
    .clk(clk), .rst_n(rst_n), .we(host_wr && hit_ring), .wslot(slot),
    .wdata(host_wdata), .cslot(cons_q), .cword(cword),
    .hslot(slot), .hword(hword));

  cmdring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .prod_we(host_wr && hit_prod),
    .prod_wval(host_wdata[PW-1:0]), .take(take), .prod_q(prod_q),
    .cons_q(cons_q), .ovf_evt(ovf_evt), .ovf_q(ovf_err));

  assign cmd_valid  = (cons_q != prod_q);
  assign take       = cmd_valid && cmd_ready;
  assign head       = cword;
  assign cmd_opcode = head.opcode;
  assign cmd_flags  = head.flags;
  assign cmd_index  = head.index;

  always_comb begin
    if (hit_ring)      host_rdata = hword;
    else if (hit_prod) host_rdata = 32'(prod_q);
    else if (hit_cons) host_rdata = 32'(cons_q);
    else               host_rdata = '0;
  end

  // R5: consumer index holds while nothing is pending
  a_r5_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> cons_q == $past(cons_q));
  // R8: a write to the consumer register leaves the index untouched when idle
  a_r8_cons_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && hit_cons && !take) |=> cons_q == $past(cons_q));
endmodule

// File: tb/sim_cmdring_mailbox.sv
`timescale 1ns/1ps
module sim_cmdring_mailbox;
  localparam int N = 64;
  localparam logic [11:0] RB = 12'h700, PA = 12'h50C, CA = 12'h62C;

  logic        clk = 0, rst_n = 0;
  logic        host_wr = 0, cmd_ready = 0;
  logic [11:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        cmd_valid, ovf_err;
  logic [7:0]  cmd_opcode;
  logic [11:0] cmd_flags, cmd_index;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] m [N];
  int unsigned p = 0, c = 0;
  bit e_ovf = 0;

  always #4 clk = ~clk;

  cmdring_mailbox u0 (.clk(clk), .rst_n(rst_n), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_flags(cmd_flags), .cmd_index(cmd_index), .ovf_err(ovf_err));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // occupancy view: a move is legal when it does not shrink the pending count
  function automatic bit move_legal(int unsigned nv, int unsigned cp, int unsigned cc);
    int unsigned occ_old = (cp + N - cc) % N;
    int unsigned occ_new = (nv + N - cc) % N;
    return occ_new >= occ_old;
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a);
    if (a[1:0] == 0 && a >= RB && a < RB + 12'd256) return m[(a - RB) >> 2];
    if (a == PA) return 32'(p);
    if (a == CA) return 32'(c);
    return 0;
  endfunction

  task automatic step(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input logic rdy, input string tag);
    bit v;
    host_wr = wr; host_addr = a; host_wdata = d; cmd_ready = rdy;
    #1;
    v = (c != p);
    chk({tag, " R4 valid"}, 32'(cmd_valid), 32'(v));
    if (v) begin
      chk({tag, " R4 opcode"}, 32'(cmd_opcode), 32'(m[c][31:24]));
      chk({tag, " R4 flags"},  32'(cmd_flags),  32'(m[c][23:12]));
      chk({tag, " R4 index"},  32'(cmd_index),  32'(m[c][11:0]));
    end
    chk({tag, " R6 ovf_err"}, 32'(ovf_err), 32'(e_ovf));
    if (!wr) chk({tag, " readback"}, host_rdata, exp_read(a));
    // model update for this edge
    e_ovf = 0;
    if (wr) begin
      if (a[1:0] == 0 && a >= RB && a < RB + 12'd256) m[(a - RB) >> 2] = d;
      else if (a == PA) begin
        if (move_legal(d % N, p, c)) p = d % N; else e_ovf = 1;
      end
    end
    if (v && rdy) c = (c + 1) % N;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    step(0, PA, 0, 0, "R1 prod");
    step(0, CA, 0, 1, "R1 cons");
    for (int i = 0; i < N; i++) step(0, RB + 12'(4 * i), 0, 0, "R1 slot");
    // R8 unmapped and misaligned reads, ignored writes
    step(1, 12'h124, 32'hFFFF_FFFF, 0, "R8 wr unmapped");
    step(0, 12'h124, 0, 0, "R8 rd unmapped");
    step(1, 12'h701, 32'h1234_5678, 0, "R8 wr misaligned");
    step(0, 12'h701, 0, 0, "R8 rd misaligned");
    step(0, RB, 0, 0, "R8 slot0 untouched");
    step(1, CA, 32'd9, 0, "R8 wr cons");
    step(0, CA, 0, 0, "R8 cons unchanged");
    // R2 fill 63 slots, R3 publish them all
    for (int i = 0; i < N - 1; i++)
      step(1, RB + 12'(4 * i), {8'(i + 1), 12'(i * 3), 12'(4095 - i)}, 0, "R2 fill");
    step(0, RB + 12'd8, 0, 0, "R2 readback");
    step(1, PA, 32'hFFFF_FF3F, 0, "R3 prod 63");
    step(0, PA, 0, 0, "R3 prod readback");
    // R6 full ring: one more step overtakes
    step(1, PA, 32'd0, 0, "R6 overtake");
    step(0, PA, 0, 0, "R6 prod kept");
    step(0, PA, 0, 0, "R6 pulse ends");
    // R7 drain across the wrap
    for (int i = 0; i < N - 1; i++) step(0, CA, 0, 1, "R7 drain");
    step(0, CA, 0, 1, "R7 cons at 63");
    step(1, RB + 12'd252, 32'hA5_123_456, 0, "R7 slot63");
    step(1, PA, 32'd2, 0, "R7 prod wraps");
    step(0, CA, 0, 0, "R5 ready low no move");
    step(0, CA, 0, 1, "R7 take 63");
    step(0, CA, 0, 1, "R7 cons wrapped");
    step(0, CA, 0, 1, "R5 empty");
    step(0, CA, 0, 1, "R5 ready while empty");
    // random mix
    for (int k = 0; k < 4000; k++) begin
      int unsigned sel = $urandom % 10;
      logic rdy = 1'($urandom % 2);
      if (sel < 4)
        step(1, RB + 12'(4 * ($urandom % N)), $urandom, rdy, "R2 rnd wr");
      else if (sel < 6)
        step(1, PA, (($urandom % 10) < 8) ? 32'((p + $urandom % 4) % N) : $urandom,
             rdy, "R3 rnd prod");
      else if (sel < 7)
        step(0, PA, 0, rdy, "R3 rnd rd");
      else if (sel < 8)
        step(0, CA, 0, rdy, "R5 rnd rd");
      else
        step(0, RB + 12'(4 * ($urandom % N)), 0, rdy, "R2 rnd rd");
    end
    r = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule